// File: doc/BRIEF.md
# Gated Pulse Counter with Byte Readout

This block counts the rising edges of a logic pulse train from an external event source while a host-held gate line is high. The pulse input is asynchronous to the system clock. It passes through a two-flop synchronizer and a rising-edge detector. Each detected edge advances a 24-bit count, which is built from two cascaded 12-bit up-counting stages. Dropping the gate freezes the count so the host can read it.

The host talks to the block through a 3-bit select code, which a one-of-eight decoder expands into eight lines. Code 0 clears both stages. Codes 1 to 4 each place one byte-wide slice of the count on a shared 8-bit bus, and only one slice drives at a time. Codes 5 to 7 are spare and drive nothing. Four reads recover the whole count.

A small control machine has three states, all reached from any state:
- ST_HOLD: the gate is low and the count is frozen. It is entered when the gate is low and no clear is requested.
- ST_COUNT: the gate is high and detected edges are counted. It is entered when the gate is high and no clear is requested.
- ST_CLEAR: a clear code is present. It is entered whenever the select code is 0, whatever the gate does, because a clear takes priority over the gate.

Top module: `gated_pulse_counter`

## Requirements
- R1: After reset the count is zero, `bus_oe` is low and `bus_data` is zero.
- R2: While the gate is high, each rising edge of `pulse_in` adds exactly one to the count. This holds for pulses that stay high for at least two clocks and low for at least two clocks, which is a pulse rate of one quarter of the clock rate.
- R3: While the gate is low, pulses on `pulse_in` are ignored and the count does not change.
- R4: Select code 0 clears both stages to zero on the next clock edge. This clear wins over a pulse counted in the same cycle.
- R5: Select code 1 drives low-stage bits 7:0 and code 2 drives low-stage bits 11:8 with the upper four bus bits zero. Codes 3 and 4 drive the same layout for the high stage. For codes 1 to 4, `bus_oe` is high.
- R6: For codes 0, 5, 6 and 7, `bus_oe` is low and `bus_data` reads zero.
- R7: The high stage advances by one when the low stage wraps from 4095 to 0.
- R8: The count at its maximum, 2^(2·STAGE_W)−1 (16777215 by default), wraps to zero on the next counted pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous event pulse train |
| gate_in | input | 1 | Count enable held by the host |
| sel_code | input | 3 | Select code: 0 clears, 1 to 4 read slices, 5 to 7 spare |
| bus_data | output | 8 | Selected count slice, zero when nothing is selected |
| bus_oe | output | 1 | High while a slice drives the bus |

## Verification
The assertions assume that `pulse_in` honours the minimum high and low times, so no edge is lost. They also assume that `gate_in` and `sel_code` come from host logic that changes them only between clock edges. The freeze check assumes the gate has been low for two consecutive cycles, to cover the one-cycle gate latency through the state register.

The bench drives every pulse high for two clocks and low for two clocks. It raises the gate two clocks before the first pulse and waits four clocks after the last pulse before it lowers the gate or reads. This keeps every edge clear of a gate transition. A second instance with 4-bit stages shares the same stimulus, so the full-count wrap is reached within the run.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_CLEAR = 2'd2
    } run_state_t;

    localparam int SEL_W      = 3;
    localparam int NUM_LINES  = 1 << SEL_W;
    localparam int SLICE_W    = 8;
    localparam int NUM_STAGES = 2;
    localparam int NUM_SLICES = 2 * NUM_STAGES;
endpackage

// File: rtl/gpc_edge_sync.sv
module gpc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic rise
);
    // chain[SYNC_STAGES-1] is the synchronized level; chain[SYNC_STAGES] is its previous value
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], pulse_in};
    end

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/gpc_cascade.sv
module gpc_cascade #(
    parameter int STAGE_W    = 12,
    parameter int NUM_STAGES = 2,
    localparam int CNT_W     = STAGE_W * NUM_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [NUM_STAGES:0] carry;
    assign carry[0] = inc;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic [STAGE_W-1:0] stage_q;
        always_ff @(posedge clk) begin
            if (!rst_n)        stage_q <= '0;
            else if (clr)      stage_q <= '0;
            else if (carry[i]) stage_q <= stage_q + 1'b1;
        end
        // the next stage steps when this one wraps from all ones
        assign carry[i+1] = carry[i] & (&stage_q);
        assign count[i*STAGE_W +: STAGE_W] = stage_q;
    end
endmodule

// File: rtl/gpc_readout.sv
module gpc_readout
    import gpc_pkg::*;
#(
    parameter int STAGE_W = 12,
    localparam int CNT_W  = STAGE_W * NUM_STAGES
) (
    input  logic [SEL_W-1:0]   sel_code,
    input  logic [CNT_W-1:0]   count,
    output logic               clr_line,
    output logic [SLICE_W-1:0] bus_data,
    output logic               bus_oe
);
    logic [NUM_LINES-1:0] lines;
    logic [SLICE_W-1:0]   slice [NUM_SLICES];

    assign lines = NUM_LINES'(1) << sel_code;

    // STAGE_W up to 16: each stage yields a low byte and a zero-extended upper part
    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        logic [15:0] ext;
        assign ext = 16'(count[(k/2)*STAGE_W +: STAGE_W]);
        if (k % 2 == 0) begin : g_lo
            assign slice[k] = ext[7:0];
        end else begin : g_hi
            assign slice[k] = ext[15:8];
        end
    end

    always_comb begin
        bus_data = '0;
        for (int k = 0; k < NUM_SLICES; k++) begin
            if (lines[k+1]) bus_data = bus_data | slice[k];
        end
    end

    assign bus_oe   = |lines[NUM_SLICES:1];
    assign clr_line = lines[0];
endmodule

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter
    import gpc_pkg::*;
#(
    parameter int STAGE_W     = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pulse_in,
    input  logic               gate_in,
    input  logic [SEL_W-1:0]   sel_code,
    output logic [SLICE_W-1:0] bus_data,
    output logic               bus_oe
);
    localparam int CNT_W = STAGE_W * NUM_STAGES;

    run_state_t       state_q, state_d;
    logic             rise, clr_line, count_en;
    logic [CNT_W-1:0] count_q;

    gpc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .rise(rise)
    );

    gpc_readout #(.STAGE_W(STAGE_W)) u_read (
        .sel_code(sel_code), .count(count_q), .clr_line(clr_line),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_HOLD;
        unique case (state_q)
            ST_HOLD, ST_COUNT, ST_CLEAR: begin
                if (clr_line)     state_d = ST_CLEAR;
                else if (gate_in) state_d = ST_COUNT;
                else              state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        count_en = 1'b0;
        unique case (state_q)
            ST_COUNT: count_en = rise & ~clr_line;
            ST_HOLD, ST_CLEAR: count_en = 1'b0;
            default: count_en = 1'b0;
        endcase
    end

    gpc_cascade #(.STAGE_W(STAGE_W), .NUM_STAGES(NUM_STAGES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_line), .inc(count_en), .count(count_q)
    );
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_in,
    input logic [2:0]       sel_code,
    input logic [7:0]       bus_data,
    input logic             bus_oe,
    input logic [CNT_W-1:0] count
);
    AST_CLEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 3'd0) |=> (count == '0)); // R4

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_in && !$past(gate_in) && sel_code != 3'd0) |=> $stable(count)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != 3'd0) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '1 && sel_code != 3'd0) |=> (count == '1 || count == '0)); // R8

    AST_SLICE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code >= 3'd1 && sel_code <= 3'd4) |-> bus_oe); // R5

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 3'd0 || sel_code > 3'd4) |-> (!bus_oe && bus_data == 8'd0)); // R6
endmodule

bind gated_pulse_counter gpc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .sel_code(sel_code),
    .bus_data(bus_data), .bus_oe(bus_oe), .count(count_q)
);

// File: tb/gated_pulse_counter_tb.sv
module gated_pulse_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_in = 1'b0;
    logic       gate_in = 1'b0;
    logic [2:0] sel_code = 3'd7;
    logic [7:0] bus_data, bus_data_s;
    logic       bus_oe, bus_oe_s;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [23:0] exp_cnt = '0;
    logic [7:0]  exp_small = '0;
    bit   gate_model = 1'b0;

    always #10 clk = ~clk;

    gated_pulse_counter u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_in(gate_in),
        .sel_code(sel_code), .bus_data(bus_data), .bus_oe(bus_oe)
    );

    // 4-bit stages: an 8-bit count whose full wrap is reachable quickly
    gated_pulse_counter #(.STAGE_W(4)) u_small (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_in(gate_in),
        .sel_code(sel_code), .bus_data(bus_data_s), .bus_oe(bus_oe_s)
    );

    function automatic logic [8:0] exp_slice(input logic [23:0] v, input int code);
        case (code)
            1: return {1'b1, v[7:0]};
            2: return {1'b1, 4'h0, v[11:8]};
            3: return {1'b1, v[19:12]};
            4: return {1'b1, 4'h0, v[23:20]};
            default: return 9'd0;
        endcase
    endfunction

    function automatic logic [8:0] exp_small_slice(input logic [7:0] v, input int code);
        case (code)
            1: return {1'b1, 4'h0, v[3:0]};
            2: return {1'b1, 8'h00};
            3: return {1'b1, 4'h0, v[7:4]};
            4: return {1'b1, 8'h00};
            default: return 9'd0;
        endcase
    endfunction

    task automatic compare(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got oe/data %h, expected %h", req, act, exp);
        end
    endtask

    task automatic read_all(input string req);
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            sel_code = 3'(c);
            #2;
            compare(req, {bus_oe, bus_data}, exp_slice(exp_cnt, c));
            compare({req, " small"}, {bus_oe_s, bus_data_s}, exp_small_slice(exp_small, c));
        end
        @(negedge clk);
        sel_code = 3'd7;
    endtask

    task automatic check_spare(input string req);
        for (int c = 5; c <= 7; c++) begin
            @(negedge clk);
            sel_code = 3'(c);
            #2;
            compare(req, {bus_oe, bus_data}, 9'd0);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        sel_code = 3'd0;
        #2;
        compare("R6 clear code idle bus", {bus_oe, bus_data}, 9'd0);
        @(negedge clk);
        sel_code = 3'd7;
        exp_cnt = '0;
        exp_small = '0;
    endtask

    task automatic one_pulse();
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk); pulse_in = 1'b0;
        @(negedge clk);
        if (gate_model) begin
            exp_cnt = exp_cnt + 1'b1;
            exp_small = exp_small + 1'b1;
        end
    endtask

    task automatic burst(input int n, input bit gated);
        @(negedge clk);
        gate_in = gated;
        gate_model = gated;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) one_pulse();
        repeat (4) @(negedge clk);
        gate_in = 1'b0;
        gate_model = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        #2;
        compare("R1 reset bus", {bus_oe, bus_data}, 9'd0);
        read_all("R1 reset count");
        check_spare("R6 spare codes");

        burst(3, 1'b1);
        read_all("R2 three pulses");
        burst(7, 1'b0);
        read_all("R3 ungated pulses ignored");
        burst(5, 1'b1);
        read_all("R2 R5 second burst");

        do_clear();
        read_all("R4 clear");

        // R4 clear wins: gate open, pulses arrive while the clear code is held
        @(negedge clk);
        gate_in = 1'b1;
        sel_code = 3'd0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); pulse_in = 1'b1;
            @(negedge clk);
            @(negedge clk); pulse_in = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        gate_in = 1'b0;
        sel_code = 3'd7;
        repeat (2) @(negedge clk);
        exp_cnt = '0;
        exp_small = '0;
        read_all("R4 clear wins over gate");

        // R8 full wrap of the 8-bit instance: 256 pulses return it to zero
        burst(256, 1'b1);
        read_all("R8 wrap to zero");

        // R7 low stage wrap into the high stage
        do_clear();
        burst(4098, 1'b1);
        read_all("R7 cascade carry");

        for (int it = 0; it < 24; it++) begin
            case ($urandom % 4)
                0: burst(int'($urandom % 40), 1'b1);
                1: burst(int'($urandom % 10), 1'b0);
                2: do_clear();
                default: check_spare("R6 spare random");
            endcase
            read_all("R2 R3 R4 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule